// File: doc/BRIEF.md
# Framed SPI Register Port

This block is the peripheral side of an SPI register interface (clock idles high; data is sampled on the rising SCLK edge and changed on the falling edge). It runs in the system clock domain and oversamples SCLK, chip select and MOSI through a synchronizer chain. Traffic moves in 16-bit segments while chip select is low. A segment whose top bit is 0 is a read request: the block fetches the addressed word from an attached register file and shifts it out MSB-first on MISO during the next segment. That next segment can be in the same chip-select window or in a later one. Reads of one reserved address return the block's own diagnostic word instead.

The port also guards its framing. A chip-select window that ends after at least one full segment but with extra clocks leaves the port misaligned by the excess count, modulo 16. While misaligned it decodes nothing. A window of exactly 17 clocks moves the misalignment on by one, so at most 15 such windows bring it back into step. A window that ends before the first full segment locks the port until the hard reset. A read budget between data-ready pulses grows with the decimation setting, and exceeding it raises a sticky overrun flag.

Top module: `spi_rport`

## Requirements
- R1: After hard reset, MISO is 0, the diagnostic word is 0 and no register-file read is issued.
- R2: A segment is a read when bit 15 is 0, with the address in bits 14..8. A read of any address other than the diagnostic address (default 0x02) gives one single-cycle rd_en pulse with that address. A segment with bit 15 set issues no read and is answered with 0.
- R3: The response to a read goes out MSB-first on MISO during the segment that follows it, with the value that rd_data held during the rd_en pulse.
- R4: A read of the diagnostic address returns the diagnostic word (overrun at bit 1, other bits 0) as it stood before that read, then clears the overrun flag. If the same read also breaks the budget, the flag is set.
- R5: Between data-ready pulses, up to 12 × (decimation setting + 1) reads are accepted. Every further read sets the overrun flag, which stays set until a diagnostic read clears it.
- R6: A data-ready pulse restarts the read count but leaves the overrun flag as it is.
- R7: A chip-select window holding 1 to 15 rising SCLK edges locks the port. While locked, MISO stays 0, no read is issued, and all SCLK and chip-select activity is ignored until the hard reset.
- R8: A window of 16 or more edges whose count is not a multiple of 16 adds the excess (count mod 16) to an offset held modulo 16. While the offset is nonzero, no segment is decoded, MISO is 0, and any pending response is dropped.
- R9: Each 17-edge window adds one to the offset. After a single misalignment of one, fifteen such windows restore decoding.
- R10: Several segments in one chip-select window are each decoded, and each one carries the response to the segment before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| sclk | input | 1 | SPI clock, idles high |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| rd_en | output | 1 | Register-file read strobe, one cycle |
| rd_addr | output | 7 | Register-file read address |
| rd_data | input | 16 | Register-file read data, valid while rd_en is high |
| drdy | input | 1 | Data-ready strobe, one cycle |
| dec_rate | input | DEC_W (16) | Decimation setting that scales the read budget |
| diag_stat | output | 16 | Diagnostic word, overrun flag at bit 1 |

## Verification
The hardest state to reach is the end of a recovery run. The port has to be misaligned first, and then it takes exactly fifteen 17-edge windows (or twelve after a 20-edge window) before a read decodes again. At no point do the ports show the offset. The bench gets there with directed windows of odd lengths, and checks after every window that a read still gives no rd_en and silent MISO, until the window that should realign it. The budget edge comes from long directed read runs at two decimation settings, checked at the 12th/13th and 36th/37th reads. Random multi-segment windows then mix reads, writes, diagnostic reads and data-ready pulses against a bench model.

// File: rtl/spi_rport_pkg.sv
package spi_rport_pkg;
   localparam int SEG_BITS   = 16;
   localparam int CNT_W      = $clog2(SEG_BITS);
   localparam int ADDR_W     = 7;
   localparam int CMD_WR_POS = 15;
   localparam int ADDR_HI    = 14;
   typedef logic [SEG_BITS-1:0] seg_t;
   typedef logic [ADDR_W-1:0]   addr_t;
   typedef logic [CNT_W-1:0]    bitpos_t;
endpackage

// File: rtl/spi_rport_sync.sv
module spi_rport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic mosi,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_fall,
   output logic cs_rise,
   output logic cs_low,
   output logic mosi_s
);
   initial begin
      assert (STAGES >= 2) else $error("sync chain needs at least two stages");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [2:0] q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 3'b110;
            else        q <= {sclk, cs_n, mosi};
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= 3'b110;
            else        q <= g_stage[g-1].q;
      end
   end

   logic [2:0] s_q;
   logic       sclk_d, cs_d;
   assign s_q = g_stage[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sclk_d <= 1'b1;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= s_q[2];
         cs_d   <= s_q[1];
      end

   assign sclk_rise = s_q[2] & ~sclk_d;
   assign sclk_fall = ~s_q[2] & sclk_d;
   assign cs_fall   = ~s_q[1] & cs_d;
   assign cs_rise   = s_q[1] & ~cs_d;
   assign cs_low    = ~s_q[1];
   assign mosi_s    = s_q[0];
endmodule

// File: rtl/spi_rport_frame.sv
module spi_rport_frame
   import spi_rport_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sclk_rise,
   input  logic    cs_fall,
   input  logic    cs_rise,
   input  logic    cs_low,
   output logic    seg_done,
   output logic    frame_bad,
   output logic    aligned,
   output logic    locked,
   output bitpos_t bit_pos
);
   initial begin
      assert (SEG_BITS == (1 << CNT_W)) else $error("segment length must be a power of two");
   end

   bitpos_t bit_cnt;
   bitpos_t offset;
   logic    full_seen;
   logic    lock_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         bit_cnt   <= '0;
         offset    <= '0;
         full_seen <= 1'b0;
         lock_q    <= 1'b0;
      end else if (!lock_q) begin
         if (cs_fall) begin
            bit_cnt   <= '0;
            full_seen <= 1'b0;
         end else if (sclk_rise && cs_low) begin
            bit_cnt <= bit_cnt + bitpos_t'(1);
            if (bit_cnt == bitpos_t'(SEG_BITS-1)) full_seen <= 1'b1;
         end
         if (cs_rise && bit_cnt != '0) begin
            if (!full_seen) lock_q <= 1'b1;
            else            offset <= offset + bit_cnt;
         end
      end

   assign seg_done  = sclk_rise && cs_low && !lock_q && offset == '0 &&
                      bit_cnt == bitpos_t'(SEG_BITS-1);
   assign frame_bad = cs_rise && !lock_q && bit_cnt != '0;
   assign aligned   = !lock_q && offset == '0;
   assign locked    = lock_q;
   assign bit_pos   = bit_cnt;

   assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);
   assert_offset_moves_at_cs_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rise |=> $stable(offset));
   assert_short_window_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && !lock_q && !full_seen && bit_cnt != '0) |=> lock_q);
endmodule

// File: rtl/spi_rport_budget.sv
module spi_rport_budget #(
   parameter int BASE_READS = 12,
   parameter int DEC_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drdy,
   input  logic             rd_evt,
   input  logic             clr_ovr,
   input  logic [DEC_W-1:0] dec_rate,
   output logic             overrun
);
   localparam int LIM_W = DEC_W + $clog2(BASE_READS + 1) + 1;

   initial begin
      assert (BASE_READS > 0) else $error("read budget must be positive");
      assert (DEC_W > 0)      else $error("decimation width must be positive");
   end

   logic [LIM_W-1:0] limit;
   logic [LIM_W-1:0] cnt;
   logic             over_set;

   assign limit    = LIM_W'(BASE_READS) * (LIM_W'(dec_rate) + LIM_W'(1));
   assign over_set = rd_evt && !drdy && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt     <= '0;
         overrun <= 1'b0;
      end else begin
         if (drdy)                        cnt <= rd_evt ? LIM_W'(1) : '0;
         else if (rd_evt && cnt < limit)  cnt <= cnt + LIM_W'(1);
         if (over_set)     overrun <= 1'b1;
         else if (clr_ovr) overrun <= 1'b0;
      end

   assert_excess_read_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_evt && !drdy && cnt >= limit) |=> overrun);
   assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !clr_ovr) |=> overrun);
   assert_drdy_restarts_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (drdy && !rd_evt) |=> cnt == '0);
endmodule

// File: rtl/spi_rport.sv
module spi_rport
   import spi_rport_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BASE_READS  = 12,
   parameter int DEC_W       = 16,
   parameter int DIAG_ADDR   = 2,
   parameter int OVR_POS     = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               mosi,
   output logic               miso,
   output logic               rd_en,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic [SEG_BITS-1:0] rd_data,
   input  logic               drdy,
   input  logic [DEC_W-1:0]   dec_rate,
   output logic [SEG_BITS-1:0] diag_stat
);
   initial begin
      assert (OVR_POS >= 0 && OVR_POS < SEG_BITS) else $error("overrun bit outside the word");
      assert (DIAG_ADDR >= 0 && DIAG_ADDR < (1 << ADDR_W)) else $error("diag address too wide");
   end

   logic    sclk_rise, sclk_fall, cs_fall, cs_rise, cs_low, mosi_s;
   logic    seg_done, frame_bad, aligned, locked;
   bitpos_t bit_pos;
   logic    overrun;

   spi_rport_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
      .cs_rise(cs_rise), .cs_low(cs_low), .mosi_s(mosi_s));

   spi_rport_frame frame_i (
      .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_fall(cs_fall),
      .cs_rise(cs_rise), .cs_low(cs_low), .seg_done(seg_done),
      .frame_bad(frame_bad), .aligned(aligned), .locked(locked), .bit_pos(bit_pos));

   // receive shift register; the full word is {rx_sh[14:0], mosi_s} at seg_done
   seg_t rx_sh;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                             rx_sh <= '0;
      else if (sclk_rise && cs_low && aligned) rx_sh <= {rx_sh[SEG_BITS-2:0], mosi_s};

   logic  cmd_wr, is_read, is_diag;
   addr_t cmd_addr;
   assign cmd_wr   = rx_sh[CMD_WR_POS-1];
   assign cmd_addr = rx_sh[ADDR_HI-1 -: ADDR_W];
   assign is_read  = seg_done && !cmd_wr;
   assign is_diag  = cmd_addr == addr_t'(DIAG_ADDR);
   assign rd_en    = is_read && !is_diag;
   assign rd_addr  = cmd_addr;

   spi_rport_budget #(.BASE_READS(BASE_READS), .DEC_W(DEC_W)) budget_i (
      .clk(clk), .rst_n(rst_n), .drdy(drdy), .rd_evt(is_read),
      .clr_ovr(is_read && is_diag), .dec_rate(dec_rate), .overrun(overrun));

   always_comb begin
      diag_stat          = '0;
      diag_stat[OVR_POS] = overrun;
   end

   // transmit shift register: loaded at segment end, shifted on falling edges
   // except the first falling edge of each segment, which presents the MSB
   seg_t tx_sh;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        tx_sh <= '0;
      else if (frame_bad || locked)      tx_sh <= '0;
      else if (seg_done)                 tx_sh <= is_read ? (is_diag ? diag_stat : rd_data) : '0;
      else if (sclk_fall && cs_low && aligned && bit_pos != '0)
                                         tx_sh <= {tx_sh[SEG_BITS-2:0], 1'b0};

   assign miso = (cs_low && aligned) ? tx_sh[SEG_BITS-1] : 1'b0;

   assert_rd_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
   assert_locked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (!rd_en && !miso));
   assert_misaligned_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned |-> (!rd_en && !miso));
   assert_diag_read_no_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && is_diag) |-> !rd_en);
endmodule

// File: tb/spi_rport_tb.sv
module spi_rport_tb_top;
   localparam int DIAG = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0, drdy = 1'b0;
   logic [15:0] dec_rate = '0;
   logic        miso, rd_en;
   logic [6:0]  rd_addr;
   logic [15:0] rd_data, diag_stat;

   always #2.5 clk = ~clk;

   function automatic logic [15:0] reg_val(logic [6:0] a);
      return {1'b1, ~a, a, 1'b0};
   endfunction

   assign rd_data = reg_val(rd_addr);

   spi_rport dut_i (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .drdy(drdy),
      .dec_rate(dec_rate), .diag_stat(diag_stat));

   int          nchecks = 0, nfail = 0, rden_seen = 0;
   logic [6:0]  last_addr = '0;
   bit          done = 1'b0;

   always @(posedge clk) if (rd_en) begin
      rden_seen++;
      last_addr = rd_addr;
   end

   // bench model
   int          m_cnt = 0, m_dec = 0, m_off = 0;
   bit          m_ovr = 0, m_lock = 0;
   logic [15:0] m_pend = '0;

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] rd_cmd(logic [6:0] a);
      return {1'b0, a, 8'h00};
   endfunction

   // model one decoded segment; returns 1 when a register-file read is expected
   function automatic bit apply_cmd(logic [15:0] c);
      int  lim;
      bit  set;
      logic [6:0] a;
      if (c[15]) begin
         m_pend = '0;
         return 0;
      end
      lim = 12 * (m_dec + 1);
      set = (m_cnt >= lim);
      if (!set) m_cnt++;
      a = c[14:8];
      if (a == 7'(DIAG)) begin
         m_pend = 16'(m_ovr) << 1;
         if (!set) m_ovr = 0;
      end else m_pend = reg_val(a);
      if (set) m_ovr = 1;
      return (a != 7'(DIAG));
   endfunction

   task automatic xfer(int nbits, logic [63:0] bits, output logic [63:0] got);
      got = '0;
      @(negedge clk);
      cs_n = 1'b0;
      #40;
      for (int i = 0; i < nbits; i++) begin
         sclk = 1'b0;
         mosi = bits[nbits-1-i];
         #40;
         got[nbits-1-i] = miso;
         sclk = 1'b1;
         #40;
      end
      #40 cs_n = 1'b1;
      #160;
   endtask

   task automatic do_frame(int nbits, logic [63:0] bits, string req);
      logic [63:0] got;
      logic [15:0] seg_in, seg_out, exp;
      int          rden_before, exp_rd;
      exp_rd = 0;
      rden_before = rden_seen;
      xfer(nbits, bits, got);
      for (int s = 0; s < nbits / 16; s++) begin
         seg_in  = 16'(bits >> (nbits - 16 * (s + 1)));
         seg_out = 16'(got >> (nbits - 16 * (s + 1)));
         if (m_lock || m_off != 0) exp = '0;
         else begin
            exp = m_pend;
            if (apply_cmd(seg_in)) exp_rd++;
         end
         chk(seg_out == exp, req, 64'(seg_out), 64'(exp));
      end
      chk(rden_seen - rden_before == exp_rd, req, 64'(rden_seen - rden_before), 64'(exp_rd));
      if (!m_lock && (nbits % 16) != 0) begin
         if (nbits < 16) m_lock = 1;
         else            m_off = (m_off + nbits % 16) % 16;
         m_pend = '0;
      end
   endtask

   task automatic pulse_drdy();
      @(negedge clk) drdy = 1'b1;
      @(negedge clk) drdy = 1'b0;
      m_cnt = 0;
   endtask

   task automatic set_dec(int v);
      @(negedge clk) dec_rate = 16'(v);
      m_dec = v;
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      m_cnt = 0; m_ovr = 0; m_off = 0; m_lock = 0; m_pend = '0;
   endtask

   task automatic chk_diag(string req);
      chk(diag_stat == (16'(m_ovr) << 1), req, 64'(diag_stat), 64'(16'(m_ovr) << 1));
   endtask

   initial begin
      #(190000 * 5);
      if (!done) begin
         nchecks++;
         nfail++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: reset state
      chk(miso == 1'b0, "R1", 64'(miso), 0);
      chk(diag_stat == '0, "R1", 64'(diag_stat), 0);
      chk(rden_seen == 0, "R1", 64'(rden_seen), 0);

      // R2, R3: single reads, write command answered with zero
      do_frame(16, 64'(rd_cmd(7'h15)), "R2");
      chk(last_addr == 7'h15, "R2", 64'(last_addr), 64'h15);
      do_frame(16, 64'(rd_cmd(7'h33)), "R3");
      do_frame(16, 64'(16'h8000 | 16'h4A00), "R2");
      do_frame(16, 64'(rd_cmd(7'h01)), "R2");
      do_frame(16, 64'(rd_cmd(7'h00)), "R3");

      // R10: three segments in one window
      do_frame(48, {16'h0, rd_cmd(7'h11), rd_cmd(7'h22), rd_cmd(7'h44)}, "R10");
      do_frame(16, 64'(rd_cmd(7'h00)), "R10");

      // R5, R6, R4: budget at decimation 0
      pulse_drdy();
      for (int i = 0; i < 12; i++) do_frame(16, 64'(rd_cmd(7'(8 + i))), "R5");
      chk_diag("R5");
      chk(diag_stat[1] == 1'b0, "R5", 64'(diag_stat), 0);
      do_frame(16, 64'(rd_cmd(7'h30)), "R5");
      chk(diag_stat[1] == 1'b1, "R5", 64'(diag_stat), 2);
      pulse_drdy();
      chk(diag_stat[1] == 1'b1, "R6", 64'(diag_stat), 2);
      do_frame(16, 64'(rd_cmd(7'(DIAG))), "R4");
      chk(diag_stat == '0, "R4", 64'(diag_stat), 0);
      do_frame(16, 64'(rd_cmd(7'h00)), "R4");
      pulse_drdy();
      for (int i = 0; i < 12; i++) do_frame(16, 64'(rd_cmd(7'(20 + i))), "R6");
      chk(diag_stat[1] == 1'b0, "R6", 64'(diag_stat), 0);

      // R5: budget at decimation 2
      set_dec(2);
      pulse_drdy();
      for (int i = 0; i < 36; i++) do_frame(16, 64'(rd_cmd(7'(40 + i))), "R5");
      chk(diag_stat[1] == 1'b0, "R5", 64'(diag_stat), 0);
      do_frame(16, 64'(rd_cmd(7'h7F)), "R5");
      chk(diag_stat[1] == 1'b1, "R5", 64'(diag_stat), 2);
      pulse_drdy();
      do_frame(16, 64'(rd_cmd(7'(DIAG))), "R4");
      do_frame(16, 64'(rd_cmd(7'h00)), "R4");
      set_dec(0);

      // R8, R9: one extra clock, then fifteen 17-edge windows
      do_frame(17, {47'h0, rd_cmd(7'h05), 1'b0}, "R8");
      do_frame(16, 64'(rd_cmd(7'h06)), "R8");
      for (int i = 0; i < 14; i++) do_frame(17, 64'h0, "R9");
      do_frame(16, 64'(rd_cmd(7'h06)), "R9");
      do_frame(17, 64'h0, "R9");
      do_frame(16, 64'(rd_cmd(7'h07)), "R9");
      do_frame(16, 64'(rd_cmd(7'h00)), "R9");
      chk(last_addr == 7'h00, "R9", 64'(last_addr), 0);

      // R8: four extra clocks need twelve 17-edge windows
      do_frame(20, 64'h0, "R8");
      do_frame(16, 64'(rd_cmd(7'h09)), "R8");
      for (int i = 0; i < 11; i++) do_frame(17, 64'h0, "R8");
      do_frame(16, 64'(rd_cmd(7'h09)), "R8");
      do_frame(17, 64'h0, "R8");
      do_frame(16, 64'(rd_cmd(7'h0A)), "R8");
      do_frame(16, 64'(rd_cmd(7'h00)), "R8");

      // R7: early release locks until reset
      do_frame(5, 64'h0, "R7");
      do_frame(16, 64'(rd_cmd(7'h0B)), "R7");
      do_frame(17, 64'h0, "R7");
      do_frame(16, 64'(rd_cmd(7'h0C)), "R7");
      do_frame(16, 64'(rd_cmd(7'h00)), "R7");
      chk(miso == 1'b0, "R7", 64'(miso), 0);
      do_reset();
      do_frame(16, 64'(rd_cmd(7'h0D)), "R7");
      do_frame(16, 64'(rd_cmd(7'h00)), "R7");

      // random mix of reads, writes, diag reads, data-ready pulses
      for (int it = 0; it < 120; it++) begin
         int r;
         r = int'($urandom % 10);
         if (r == 0) pulse_drdy();
         else if (r == 1) set_dec(int'($urandom % 3));
         else begin
            int          nseg;
            logic [63:0] bits;
            bits = '0;
            nseg = 1 + int'($urandom % 3);
            for (int s = 0; s < nseg; s++) begin
               logic [15:0] c;
               int          k;
               k = int'($urandom % 10);
               if (k == 0)      c = 16'h8000 | 16'($urandom % 32768);
               else if (k < 3)  c = rd_cmd(7'(DIAG));
               else             c = rd_cmd(7'($urandom % 128));
               bits = (bits << 16) | 64'(c);
            end
            do_frame(16 * nseg, bits, "R10");
            chk_diag("R5");
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end
endmodule